// File: doc/BRIEF.md
# Floating-Point Compare into Boolean Register

This block compares two single-precision floating-point operands and stores the one-bit result in one chosen bit of a 16-bit boolean register that it holds. A 3-bit code picks the predicate. The predicate is either an ordered relation (equal, less, less-or-equal), an unordered-or relation, or the bare unordered test. A 4-bit index picks the bit to write. Every other bit of the register keeps its value, so software can build up several condition flags over a sequence of compares.

The comparisons are quiet, and a quiet NaN raises no exception. A signaling NaN on either operand raises a one-cycle invalid pulse, and the result is still written. Code 0 is reserved: it leaves the register untouched and raises a one-cycle illegal-operation pulse. All outputs are registered and change on the clock edge that samples a valid request.

Top module: `fcmp_breg_unit`

## Requirements
- R1: While reset is high and on the cycle after it, `breg_o` is all zeros and `invalid_o` and `illegal_o` are low.
- R2: On a clock edge with `valid_i` high, the predicate result is written into bit `dst_i` of `breg_o` and is visible after that same edge. The codes are 1=unordered, 2=ordered-equal, 3=unordered-or-equal, 4=ordered-less, 5=unordered-or-less, 6=ordered-less-or-equal, 7=unordered-or-less-or-equal, each with operand a on the left.
- R3: The unordered predicate (code 1) gives 1 exactly when at least one operand is a NaN. A NaN has all exponent bits at one and a nonzero fraction.
- R4: Codes 2, 4 and 6 give 0 whenever either operand is a NaN.
- R5: Codes 3, 5 and 7 give 1 whenever either operand is a NaN.
- R6: +0 (0x00000000) and -0 (0x80000000) compare equal, and neither is less than the other.
- R7: For non-NaN operands, ordering follows real value. This covers negative numbers, denormals and both infinities.
- R8: A write changes only bit `dst_i`. All other bits of `breg_o` keep their values.
- R9: For a valid request with a legal code, `invalid_o` is high for exactly the following cycle when an operand is a signaling NaN (a NaN with fraction MSB bit 22 clear). A quiet NaN (fraction MSB set) leaves `invalid_o` low.
- R10: A valid request with code 0 leaves `breg_o` unchanged, raises `illegal_o` for one cycle and keeps `invalid_o` low.
- R11: With `valid_i` low, `breg_o` holds and both pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| pred_i | input | 3 | Predicate code |
| dst_i | input | 4 | Destination bit index |
| opa_i | input | 32 | Left operand a |
| opb_i | input | 32 | Right operand b |
| breg_o | output | 16 | Boolean register contents |
| invalid_o | output | 1 | One-cycle invalid pulse (signaling NaN seen) |
| illegal_o | output | 1 | One-cycle reserved-code pulse |

## Verification
The bench builds the block with its defaults: an 8-bit exponent, a 23-bit fraction and a 16-bit boolean register. These values bring IEEE single-precision encodings into reach, so exact values can be used as stimulus: both zeros, denormals, both infinities, and quiet and signaling NaNs. The bench drives every predicate code, including the reserved one, across ordered, equal and unordered operand pairs. It writes to the lowest, the highest and the middle bit indices, so the bench can watch set-then-clear sequences on one bit while the neighbouring bits must hold.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [2:0] {
    PRED_RSVD = 3'd0,
    PRED_UN   = 3'd1,
    PRED_OEQ  = 3'd2,
    PRED_UEQ  = 3'd3,
    PRED_OLT  = 3'd4,
    PRED_ULT  = 3'd5,
    PRED_OLE  = 3'd6,
    PRED_ULE  = 3'd7
  } pred_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } opclass_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0]      op_i,
  output fcmp_pkg::opclass_t   cls_o
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  assign expo = op_i[FP_W-2 -: EXP_W];
  assign frac = op_i[MAN_W-1:0];

  always_comb begin
    cls_o.is_nan  = (&expo) && (|frac);
    cls_o.is_snan = (&expo) && (|frac) && !frac[MAN_W-1];
    cls_o.is_zero = !(|op_i[FP_W-2:0]);
  end
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W = 1 + EXP_W + MAN_W,
  localparam int MAG_W = FP_W - 1
) (
  input  logic [FP_W-1:0]     a_i,
  input  logic [FP_W-1:0]     b_i,
  input  fcmp_pkg::opclass_t  cls_a_i,
  input  fcmp_pkg::opclass_t  cls_b_i,
  output logic                lt_o,
  output logic                eq_o,
  output logic                un_o
);
  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             mag_lt, mag_gt, both_zero;

  assign sa = a_i[FP_W-1];
  assign sb = b_i[FP_W-1];
  assign ma = a_i[MAG_W-1:0];
  assign mb = b_i[MAG_W-1:0];
  assign mag_lt = ma < mb;
  assign mag_gt = ma > mb;
  assign both_zero = cls_a_i.is_zero && cls_b_i.is_zero;

  always_comb begin
    un_o = cls_a_i.is_nan || cls_b_i.is_nan;
    eq_o = 1'b0;
    lt_o = 1'b0;
    if (!un_o) begin
      if (both_zero) begin
        eq_o = 1'b1;
      end else if (sa != sb) begin
        lt_o = sa;
      end else begin
        eq_o = (ma == mb);
        lt_o = sa ? mag_gt : mag_lt;
      end
    end
  end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate (
  input  logic [2:0] code_i,
  input  logic       lt_i,
  input  logic       eq_i,
  input  logic       un_i,
  output logic       res_o,
  output logic       rsvd_o
);
  import fcmp_pkg::*;

  always_comb begin
    rsvd_o = 1'b0;
    unique case (pred_e'(code_i))
      PRED_UN:  res_o = un_i;
      PRED_OEQ: res_o = eq_i;
      PRED_UEQ: res_o = eq_i | un_i;
      PRED_OLT: res_o = lt_i;
      PRED_ULT: res_o = lt_i | un_i;
      PRED_OLE: res_o = lt_i | eq_i;
      PRED_ULE: res_o = lt_i | eq_i | un_i;
      default: begin
        res_o  = 1'b0;
        rsvd_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fcmp_bool_reg.sv
module fcmp_bool_reg #(
  parameter int NBITS = 16,
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] q_o
);
  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        q_o[g] <= 1'b0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        q_o[g] <= bit_i;
      end
    end
  end
endmodule

// File: rtl/fcmp_breg_unit.sv
module fcmp_breg_unit #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int NBITS = 16,
  localparam int FP_W  = 1 + EXP_W + MAN_W,
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [2:0]       pred_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [FP_W-1:0]  opa_i,
  input  logic [FP_W-1:0]  opb_i,
  output logic [NBITS-1:0] breg_o,
  output logic             invalid_o,
  output logic             illegal_o
);
  import fcmp_pkg::*;

  logic [FP_W-1:0] ops [2];
  opclass_t        cls [2];
  logic            lt, eq, un, res, rsvd;

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i (ops[k]),
      .cls_o(cls[k])
    );
  end

  fcmp_relation #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .cls_a_i(cls[0]),
    .cls_b_i(cls[1]),
    .lt_o   (lt),
    .eq_o   (eq),
    .un_o   (un)
  );

  fcmp_predicate u_pred (
    .code_i(pred_i),
    .lt_i  (lt),
    .eq_i  (eq),
    .un_i  (un),
    .res_o (res),
    .rsvd_o(rsvd)
  );

  fcmp_bool_reg #(.NBITS(NBITS)) u_breg (
    .clk  (clk),
    .rst  (rst),
    .we_i (valid_i && !rsvd),
    .idx_i(dst_i),
    .bit_i(res),
    .q_o  (breg_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      invalid_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      invalid_o <= valid_i && !rsvd && (cls[0].is_snan || cls[1].is_snan);
      illegal_o <= valid_i && rsvd;
    end
  end
endmodule

// File: rtl/fcmp_breg_unit_chk.sv
module fcmp_breg_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int NBITS = 16,
  localparam int FP_W  = 1 + EXP_W + MAN_W,
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_i,
  input logic [2:0]       pred_i,
  input logic [IDX_W-1:0] dst_i,
  input logic [FP_W-1:0]  opa_i,
  input logic [FP_W-1:0]  opb_i,
  input logic [NBITS-1:0] breg_o,
  input logic             invalid_o,
  input logic             illegal_o
);
  logic [NBITS-1:0] keep_mask;
  logic             any_nan;
  logic             ordered_code;

  assign keep_mask = ~({{(NBITS-1){1'b0}}, 1'b1} << dst_i);
  assign any_nan = ((opa_i[FP_W-2:0] > {{EXP_W{1'b1}}, {MAN_W{1'b0}}})) ||
                   ((opb_i[FP_W-2:0] > {{EXP_W{1'b1}}, {MAN_W{1'b0}}}));
  assign ordered_code = (pred_i == 3'd2) || (pred_i == 3'd4) || (pred_i == 3'd6);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (breg_o == '0 && !invalid_o && !illegal_o));

  a_r8_others_kept: assert property (@(posedge clk) disable iff (rst)
    (valid_i && pred_i != 3'd0) |=> ((breg_o & $past(keep_mask)) == ($past(breg_o) & $past(keep_mask))));

  a_r4_ordered_nan_false: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ordered_code && any_nan) |=> !breg_o[$past(dst_i)]);

  a_r5_unordered_nan_true: assert property (@(posedge clk) disable iff (rst)
    (valid_i && pred_i[0] && any_nan) |=> breg_o[$past(dst_i)]);

  a_r10_reserved_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_i && pred_i == 3'd0) |=> (illegal_o && !invalid_o && $stable(breg_o)));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(breg_o) && !invalid_o && !illegal_o));

  a_r9_invalid_needs_nan: assert property (@(posedge clk) disable iff (rst)
    invalid_o |-> $past(valid_i && any_nan));
endmodule

bind fcmp_breg_unit fcmp_breg_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .NBITS(NBITS)) u_chk (.*);

// File: tb/fcmp_breg_unit_tb_top.sv
module fcmp_breg_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  pred_i = '0;
  logic [3:0]  dst_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [15:0] breg_o;
  logic        invalid_o, illegal_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] model_breg = '0;
  bit done = 0;

  typedef struct {
    logic [15:0] breg;
    logic        inv;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
  localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] PI = 32'h7F800000, NI = 32'hFF800000;
  localparam logic [31:0] QN = 32'h7FC00000, SN = 32'h7F800001;
  localparam logic [31:0] DN = 32'h00000001, NQN = 32'hFFC00001;

  always #5 clk = ~clk;

  fcmp_breg_unit dut_i (.*);

  function automatic bit m_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [32:0] m_key(logic [31:0] x);
    if (x[30:0] == 0) return 33'h100000000;
    if (x[31]) return {1'b0, ~x};
    return {1'b1, x};
  endfunction

  task automatic apply(input logic v, input logic [2:0] c, input logic [3:0] d,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    exp_t e;
    bit un, lt, eq, r;
    @(negedge clk);
    valid_i = v; pred_i = c; dst_i = d; opa_i = a; opb_i = b;
    un = m_nan(a) || m_nan(b);
    lt = !un && (m_key(a) < m_key(b));
    eq = !un && (m_key(a) == m_key(b));
    case (c)
      3'd1: r = un;
      3'd2: r = eq;
      3'd3: r = eq || un;
      3'd4: r = lt;
      3'd5: r = lt || un;
      3'd6: r = lt || eq;
      default: r = lt || eq || un;
    endcase
    e.inv = 1'b0; e.ill = 1'b0;
    if (v && c == 3'd0) e.ill = 1'b1;
    else if (v) begin
      model_breg[d] = r;
      e.inv = (m_nan(a) && !a[22]) || (m_nan(b) && !b[22]);
    end
    e.breg = model_breg;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_vec++;
        if (breg_o !== e.breg || invalid_o !== e.inv || illegal_o !== e.ill) begin
          n_bad++;
          $display("FAIL %s: breg=%h inv=%b ill=%b expected breg=%h inv=%b ill=%b",
                   e.tag, breg_o, invalid_o, illegal_o, e.breg, e.inv, e.ill);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    n_vec++;
    if (breg_o !== 16'h0 || invalid_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: breg=%h inv=%b ill=%b expected 0000 0 0", breg_o, invalid_o, illegal_o);
    end
    rst = 1'b0;
    // R2 / R7 ordinary ordering, each code
    apply(1, 3'd4, 4'd0,  P1, P2, "R2 olt 1<2");
    apply(1, 3'd4, 4'd1,  P2, P1, "R2 olt 2<1");
    apply(1, 3'd2, 4'd2,  P1, P1, "R2 oeq 1==1");
    apply(1, 3'd6, 4'd3,  N2, N1, "R7 ole -2<=-1");
    apply(1, 3'd5, 4'd4,  N1, N2, "R7 ult -1<-2");
    apply(1, 3'd4, 4'd5,  NI, N2, "R7 olt -inf<-2");
    apply(1, 3'd4, 4'd6,  P2, PI, "R7 olt 2<inf");
    apply(1, 3'd4, 4'd7,  PZ, DN, "R7 olt 0<denorm");
    apply(1, 3'd7, 4'd8,  P2, P1, "R7 ule 2<=1");
    apply(1, 3'd3, 4'd9,  P1, P2, "R2 ueq 1,2");
    apply(1, 3'd1, 4'd10, P1, P2, "R3 un numbers");
    // R6 signed zeros
    apply(1, 3'd2, 4'd11, PZ, NZ, "R6 oeq +0,-0");
    apply(1, 3'd4, 4'd12, NZ, PZ, "R6 olt -0<+0");
    apply(1, 3'd6, 4'd13, PZ, NZ, "R6 ole +0<=-0");
    // R3 R4 R5 NaN handling (quiet)
    apply(1, 3'd1, 4'd14, QN, P1, "R3 un qnan");
    apply(1, 3'd2, 4'd15, QN, QN, "R4 oeq qnan");
    apply(1, 3'd4, 4'd0,  P1, NQN, "R4 olt nan");
    apply(1, 3'd6, 4'd2,  NQN, P1, "R4 ole nan");
    apply(1, 3'd3, 4'd1,  P1, QN, "R5 ueq nan");
    apply(1, 3'd5, 4'd5,  QN, P1, "R5 ult nan");
    apply(1, 3'd7, 4'd8,  PI, QN, "R5 ule nan");
    // R9 signaling NaN
    apply(1, 3'd1, 4'd9,  SN, P1, "R9 snan a");
    apply(1, 3'd7, 4'd15, P1, SN, "R9 snan b");
    apply(1, 3'd2, 4'd3,  SN, SN, "R9 snan oeq");
    // R8 set then clear, neighbours held
    apply(1, 3'd4, 4'd7,  P1, P2, "R8 set bit7");
    apply(1, 3'd4, 4'd7,  P2, P1, "R8 clear bit7");
    apply(1, 3'd4, 4'd15, P2, P1, "R8 clear bit15");
    // R10 reserved code, including snan operands
    apply(1, 3'd0, 4'd4,  P1, P2, "R10 reserved");
    apply(1, 3'd0, 4'd14, SN, P1, "R10 reserved snan");
    // R11 idle with live-looking inputs
    apply(0, 3'd1, 4'd4,  QN, SN, "R11 idle");
    apply(0, 3'd0, 4'd6,  P1, P2, "R11 idle rsvd");
    apply(1, 3'd2, 4'd6,  P1, P1, "R2 back-to-back");
    @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule